// File: doc/BRIEF.md
# Degraded Read Completion with Erasure Rebuild

This block finishes a read from a memory rank in which one of the six chips holding a block may be busy with refresh. Four chips carry data symbols. Chip 4 holds the plain XOR of the four data symbols. Chip 5 holds the XOR of the data symbols after each is rotated left by its own chip number. The read does not wait for the busy chip. Its symbol is treated as an erasure and is rebuilt from the other symbols. Whatever redundancy is left is then used to check for hardware faults that nobody knew about.

A clean check returns the block on the next cycle. A failed check waits for the refresh to finish, if one was in progress. It then asks for the whole block again and sends the re-fetched block through a single-symbol corrector. Only one read is handled at a time. The response input stays not-ready from acceptance until the result has been taken at the output.

The control is a five-state machine:

| State | Meaning |
|---|---|
| `S_IDLE` | Ready for a response. |
| `S_HOLD` | Waiting for the refresh to complete. |
| `S_ISSUE` | Re-read request asserted for one cycle. |
| `S_FETCH` | Waiting for the re-fetched symbols. |
| `S_RESP` | Result presented at the output. |

Transitions:
- accept-clean: `S_IDLE` to `S_RESP`.
- accept-fault-busy: `S_IDLE` to `S_HOLD`.
- accept-fault-idle: `S_IDLE` to `S_ISSUE`.
- refresh-over: `S_HOLD` to `S_ISSUE`.
- request-sent: `S_ISSUE` to `S_FETCH`.
- refetch-arrived: `S_FETCH` to `S_RESP`.
- taken: `S_RESP` to `S_IDLE`.

Top module: `degraded_read_ctrl`

## Requirements
- R1: After reset, `rsp_ready` is 1, `out_valid` is 0 and `reread_req` is 0.
- R2: Symbol of chip c sits at bits [c*SYM_W +: SYM_W] of `rsp_syms` and `rrd_syms`. Chips 0..3 are data, chip 4 is the XOR of the data, and chip 5 is the XOR of data symbol i rotated left by i. With `rsp_rfsh_on`=0, or with an index of 6 or 7, both checks are applied. If both pass, `out_valid` rises in the cycle after acceptance, with `out_data` equal to the data chips (chip i at bits [i*SYM_W +: SYM_W]) and `out_status`=0 (direct).
- R3: With `rsp_rfsh_on`=1 and `rsp_rfsh_idx` in 0..3, the busy chip's input lane is ignored. Its symbol is rebuilt as chip 4 XOR the other three data symbols. If the chip-5 check then passes, the rebuilt block is returned the next cycle with status 0.
- R4: If chip 4 is busy, only the chip-5 check is applied. If chip 5 is busy, only the chip-4 check is applied. The busy lane's content has no effect on the result.
- R5: If a check fails while a chip is busy, nothing is output and `reread_req` stays 0 until `rfsh_done` has been sampled high. `reread_req` is then high for exactly the following cycle.
- R6: If a check fails with no chip busy, `reread_req` is high in the cycle right after acceptance.
- R7: When `rrd_valid` is sampled in the fetch state, the result appears the next cycle. If the data syndrome (chip 4 XOR the data XOR) is 0 and the rotated syndrome is 0, the re-fetched data is returned with status 1 (re-read clean).
- R8: If the data syndrome Sp is nonzero and exactly one data index i gives rotl(Sp,i) equal to the rotated syndrome, data chip i is XORed with Sp and returned with status 2 (corrected).
- R9: Any other syndrome pattern is returned with status 3 (uncorrectable) and the raw re-fetched data. This covers a fault in chip 4 only, a fault in chip 5 only, and an Sp that matches at more than one index.
- R10: While `out_valid` is high and `out_ready` is low, `out_data` and `out_status` hold and `rsp_ready` stays 0. `rsp_ready` returns to 1 in the cycle after the output is taken.
- R11: `rrd_valid` outside the fetch state has no effect. No output appears and the next read completes normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rsp_valid | input | 1 | Read response present |
| rsp_ready | output | 1 | Block can accept a response |
| rsp_syms | input | 6*SYM_W | Symbols from all six chips |
| rsp_rfsh_on | input | 1 | One chip of this read is refreshing |
| rsp_rfsh_idx | input | 3 | Index of the refreshing chip |
| rfsh_done | input | 1 | Refresh of the busy chip has finished |
| reread_req | output | 1 | One-cycle request to fetch the block again |
| rrd_valid | input | 1 | Re-fetched symbols present |
| rrd_syms | input | 6*SYM_W | Re-fetched symbols from all six chips |
| out_valid | output | 1 | Completed block present |
| out_ready | input | 1 | Consumer takes the block |
| out_data | output | 4*SYM_W | Completed data block |
| out_status | output | 2 | 0 direct, 1 re-read clean, 2 corrected, 3 uncorrectable |

## Verification
Several internal faults show up at the ports with a fixed delay:
- A mis-decoded state shows as `rsp_ready` and `out_valid` both high.
- A lost transition shows as an output that never comes, which the bench catches within a few cycles.
- A request fired too early shows as `reread_req` while the refresh is still running. The bench holds `rfsh_done` low for several cycles to expose it.

A wrong erasure index or a wrong rotation amount shows as the wrong data or status one cycle after acceptance or after the re-fetch. The cases are chosen so that each chip position and each syndrome class gives a result different from its neighbours.

// File: rtl/dgr_pkg.sv
package dgr_pkg;
    localparam int NUM_DATA  = 4;
    localparam int NUM_CHIPS = 6;
    localparam int P_CHIP    = 4;
    localparam int Q_CHIP    = 5;
    localparam int IDX_W     = 3;

    typedef enum logic [1:0] {
        RS_DIRECT    = 2'd0,
        RS_REREAD_OK = 2'd1,
        RS_FIXED     = 2'd2,
        RS_UNFIXABLE = 2'd3
    } rd_status_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_HOLD,
        S_ISSUE,
        S_FETCH,
        S_RESP
    } rd_state_e;
endpackage

// File: rtl/dgr_qsum.sv
// Plain and rotated XOR sums over the data symbols.
module dgr_qsum
    import dgr_pkg::*;
#(
    parameter int SYM_W = 8
) (
    input  logic [NUM_DATA*SYM_W-1:0] data,
    output logic [SYM_W-1:0]          psum,
    output logic [SYM_W-1:0]          qsum
);
    logic [SYM_W-1:0] rot [NUM_DATA];

    for (genvar i = 0; i < NUM_DATA; i++) begin : g_rot
        logic [2*SYM_W-1:0] dbl;
        assign dbl    = {data[i*SYM_W +: SYM_W], data[i*SYM_W +: SYM_W]};
        assign rot[i] = dbl[2*SYM_W-1-i -: SYM_W];
    end

    always_comb begin
        psum = '0;
        qsum = '0;
        for (int i = 0; i < NUM_DATA; i++) begin
            psum = psum ^ data[i*SYM_W +: SYM_W];
            qsum = qsum ^ rot[i];
        end
    end
endmodule

// File: rtl/dgr_recon.sv
// Erasure rebuild of the busy chip plus a check with the redundancy left over.
module dgr_recon
    import dgr_pkg::*;
#(
    parameter int SYM_W = 8
) (
    input  logic [NUM_CHIPS*SYM_W-1:0] syms,
    input  logic                       miss_on,
    input  logic [IDX_W-1:0]           miss_idx,
    output logic [NUM_DATA*SYM_W-1:0]  data,
    output logic                       err
);
    localparam int DW = NUM_DATA*SYM_W;

    logic [SYM_W-1:0] par_sym, rot_sym, rebuilt, lane, acc;
    logic [SYM_W-1:0] psum, qsum;
    logic             chk_p, chk_q;

    assign par_sym = syms[P_CHIP*SYM_W +: SYM_W];
    assign rot_sym = syms[Q_CHIP*SYM_W +: SYM_W];

    always_comb begin
        acc = '0;
        for (int i = 0; i < NUM_DATA; i++) begin
            lane = syms[i*SYM_W +: SYM_W];
            if (miss_on && miss_idx == IDX_W'(i)) lane = '0;
            acc = acc ^ lane;
        end
        rebuilt = par_sym ^ acc;
        data = syms[DW-1:0];
        for (int i = 0; i < NUM_DATA; i++) begin
            if (miss_on && miss_idx == IDX_W'(i)) data[i*SYM_W +: SYM_W] = rebuilt;
        end
    end

    dgr_qsum #(.SYM_W(SYM_W)) u_sum (
        .data (data),
        .psum (psum),
        .qsum (qsum)
    );

    assign chk_p = !(miss_on && miss_idx == IDX_W'(P_CHIP));
    assign chk_q = !(miss_on && miss_idx == IDX_W'(Q_CHIP));
    assign err   = (chk_p && (psum != par_sym)) || (chk_q && (qsum != rot_sym));
endmodule

// File: rtl/dgr_fix.sv
// Single-symbol corrector applied to a fully re-fetched block.
module dgr_fix
    import dgr_pkg::*;
#(
    parameter int SYM_W = 8
) (
    input  logic [NUM_CHIPS*SYM_W-1:0] syms,
    output logic [NUM_DATA*SYM_W-1:0]  data,
    output rd_status_e                 status
);
    localparam int DW = NUM_DATA*SYM_W;

    logic [SYM_W-1:0]    psum, qsum, sp, sq;
    logic [NUM_DATA-1:0] match;

    dgr_qsum #(.SYM_W(SYM_W)) u_sum (
        .data (syms[DW-1:0]),
        .psum (psum),
        .qsum (qsum)
    );

    assign sp = psum ^ syms[P_CHIP*SYM_W +: SYM_W];
    assign sq = qsum ^ syms[Q_CHIP*SYM_W +: SYM_W];

    for (genvar i = 0; i < NUM_DATA; i++) begin : g_loc
        logic [2*SYM_W-1:0] dbl;
        assign dbl      = {sp, sp};
        assign match[i] = (dbl[2*SYM_W-1-i -: SYM_W] == sq);
    end

    always_comb begin
        data   = syms[DW-1:0];
        status = RS_UNFIXABLE;
        if (sp == '0 && sq == '0) begin
            status = RS_REREAD_OK;
        end else if (sp != '0 && $countones(match) == 1) begin
            status = RS_FIXED;
            for (int i = 0; i < NUM_DATA; i++) begin
                if (match[i]) data[i*SYM_W +: SYM_W] = data[i*SYM_W +: SYM_W] ^ sp;
            end
        end
    end
endmodule

// File: rtl/degraded_read_ctrl.sv
module degraded_read_ctrl
    import dgr_pkg::*;
#(
    parameter int SYM_W = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       rsp_valid,
    output logic                       rsp_ready,
    input  logic [NUM_CHIPS*SYM_W-1:0] rsp_syms,
    input  logic                       rsp_rfsh_on,
    input  logic [IDX_W-1:0]           rsp_rfsh_idx,
    input  logic                       rfsh_done,
    output logic                       reread_req,
    input  logic                       rrd_valid,
    input  logic [NUM_CHIPS*SYM_W-1:0] rrd_syms,
    output logic                       out_valid,
    input  logic                       out_ready,
    output logic [NUM_DATA*SYM_W-1:0]  out_data,
    output logic [1:0]                 out_status
);
    localparam int DW = NUM_DATA*SYM_W;

    rd_state_e        state_q, state_d;
    logic [DW-1:0]    data_q;
    rd_status_e       stat_q;
    logic [DW-1:0]    rec_data, fix_data;
    logic             rec_err, chip_busy, accept;
    rd_status_e       fix_stat;

    dgr_recon #(.SYM_W(SYM_W)) u_recon (
        .syms     (rsp_syms),
        .miss_on  (rsp_rfsh_on),
        .miss_idx (rsp_rfsh_idx),
        .data     (rec_data),
        .err      (rec_err)
    );

    dgr_fix #(.SYM_W(SYM_W)) u_fix (
        .syms   (rrd_syms),
        .data   (fix_data),
        .status (fix_stat)
    );

    assign chip_busy = rsp_rfsh_on && (rsp_rfsh_idx < IDX_W'(NUM_CHIPS));
    assign accept    = rsp_valid && (state_q == S_IDLE);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (rsp_valid) state_d = !rec_err ? S_RESP : (chip_busy ? S_HOLD : S_ISSUE);
            S_HOLD:  if (rfsh_done) state_d = S_ISSUE;
            S_ISSUE: state_d = S_FETCH;
            S_FETCH: if (rrd_valid) state_d = S_RESP;
            S_RESP:  if (out_ready) state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            stat_q <= RS_DIRECT;
        end else if (accept) begin
            data_q <= rec_data;
            stat_q <= RS_DIRECT;
        end else if (state_q == S_FETCH && rrd_valid) begin
            data_q <= fix_data;
            stat_q <= fix_stat;
        end
    end

    always_comb begin
        rsp_ready  = (state_q == S_IDLE);
        reread_req = (state_q == S_ISSUE);
        out_valid  = (state_q == S_RESP);
        out_data   = data_q;
        out_status = stat_q;
    end
endmodule

// File: rtl/dgr_read_chk.sv
module dgr_read_chk
    import dgr_pkg::*;
#(
    parameter int SYM_W = 8
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      rsp_valid,
    input logic                      rsp_ready,
    input logic                      rsp_rfsh_on,
    input logic [IDX_W-1:0]          rsp_rfsh_idx,
    input logic                      reread_req,
    input logic                      out_valid,
    input logic                      out_ready,
    input logic [NUM_DATA*SYM_W-1:0] out_data,
    input logic [1:0]                out_status
);
    logic saw_req;

    always_ff @(posedge clk) begin
        if (!rst_n)                     saw_req <= 1'b0;
        else if (reread_req)            saw_req <= 1'b1;
        else if (out_valid && out_ready) saw_req <= 1'b0;
    end

    // R10
    hold_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_status));

    // R10
    single_flight_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_ready && out_valid));

    // R5
    req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reread_req |=> !reread_req && !rsp_ready && !out_valid);

    // R5
    busy_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_ready && rsp_rfsh_on && (rsp_rfsh_idx < 3'd6) |=> !reread_req);

    // R2
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_ready |=> !rsp_ready);

    // R7
    status_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && (out_status != 2'd0) |-> saw_req);
endmodule

bind degraded_read_ctrl dgr_read_chk #(.SYM_W(SYM_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .rsp_valid    (rsp_valid),
    .rsp_ready    (rsp_ready),
    .rsp_rfsh_on  (rsp_rfsh_on),
    .rsp_rfsh_idx (rsp_rfsh_idx),
    .reread_req   (reread_req),
    .out_valid    (out_valid),
    .out_ready    (out_ready),
    .out_data     (out_data),
    .out_status   (out_status)
);

// File: tb/degraded_read_ctrl_tb.sv
module degraded_read_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rsp_valid = 1'b0;
    logic        rsp_ready;
    logic [47:0] rsp_syms = '0;
    logic        rsp_rfsh_on = 1'b0;
    logic [2:0]  rsp_rfsh_idx = '0;
    logic        rfsh_done = 1'b0;
    logic        reread_req;
    logic        rrd_valid = 1'b0;
    logic [47:0] rrd_syms = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [31:0] out_data;
    logic [1:0]  out_status;

    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    degraded_read_ctrl #(.SYM_W(8)) u_dut (
        .clk(clk), .rst_n(rst_n), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
        .rsp_syms(rsp_syms), .rsp_rfsh_on(rsp_rfsh_on), .rsp_rfsh_idx(rsp_rfsh_idx),
        .rfsh_done(rfsh_done), .reread_req(reread_req), .rrd_valid(rrd_valid),
        .rrd_syms(rrd_syms), .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data), .out_status(out_status)
    );

    function automatic logic [7:0] brot(input logic [7:0] x, input int n);
        logic [7:0] r;
        for (int b = 0; b < 8; b++) r[(b + n) % 8] = x[b];
        return r;
    endfunction

    function automatic logic [47:0] enc(input logic [31:0] d);
        logic [7:0] p, q;
        p = '0; q = '0;
        for (int i = 0; i < 4; i++) begin
            p = p ^ d[i*8 +: 8];
            q = q ^ brot(d[i*8 +: 8], i);
        end
        return {q, p, d};
    endfunction

    function automatic logic [47:0] flip(input logic [47:0] s, input int c, input logic [7:0] e);
        logic [47:0] r;
        r = s;
        r[c*8 +: 8] = r[c*8 +: 8] ^ e;
        return r;
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle_ok(input string req);
        chk(req, {63'd0, out_valid}, 64'd0);
        chk(req, {63'd0, rsp_ready}, 64'd1);
    endtask

    // Accept one response; returns at the negedge after the accepting edge.
    task automatic send(input logic [47:0] s, input logic on, input logic [2:0] idx);
        @(negedge clk);
        rsp_valid = 1'b1; rsp_syms = s; rsp_rfsh_on = on; rsp_rfsh_idx = idx;
        @(negedge clk);
        rsp_valid = 1'b0; rsp_syms = '0; rsp_rfsh_on = 1'b0;
    endtask

    task automatic fast_read(input string req, input logic [47:0] s, input logic on,
                             input logic [2:0] idx, input logic [31:0] exp);
        send(s, on, idx);
        chk(req, {63'd0, out_valid}, 64'd1);
        chk(req, {32'd0, out_data}, {32'd0, exp});
        chk(req, {62'd0, out_status}, 64'd0);
        @(negedge clk);
        idle_ok(req);
    endtask

    task automatic slow_read(input string req, input logic [47:0] s, input logic on,
                             input logic [2:0] idx, input logic [47:0] rr,
                             input logic [31:0] exp, input logic [1:0] st);
        send(s, on, idx);
        chk(req, {63'd0, out_valid}, 64'd0);
        chk(req, {63'd0, rsp_ready}, 64'd0);
        if (on) begin
            for (int k = 0; k < 3; k++) begin
                chk({req, " R5 wait"}, {63'd0, reread_req}, 64'd0);
                @(negedge clk);
            end
            chk({req, " R5 wait"}, {63'd0, reread_req}, 64'd0);
            rfsh_done = 1'b1;
            @(negedge clk);
            rfsh_done = 1'b0;
        end
        chk({req, " request"}, {63'd0, reread_req}, 64'd1);
        @(negedge clk);
        chk({req, " pulse"}, {63'd0, reread_req}, 64'd0);
        rrd_valid = 1'b1; rrd_syms = rr;
        @(negedge clk);
        rrd_valid = 1'b0; rrd_syms = '0;
        chk(req, {63'd0, out_valid}, 64'd1);
        chk(req, {32'd0, out_data}, {32'd0, exp});
        chk(req, {62'd0, out_status}, {62'd0, st});
        @(negedge clk);
        idle_ok(req);
    endtask

    task automatic t_reset;
        chk("R1 ready", {63'd0, rsp_ready}, 64'd1);
        chk("R1 valid", {63'd0, out_valid}, 64'd0);
        chk("R1 req", {63'd0, reread_req}, 64'd0);
    endtask

    task automatic t_clean;
        fast_read("R2 clean a", enc(32'h44332211), 1'b0, 3'd0, 32'h44332211);
        fast_read("R2 clean b", enc(32'hDEADBEEF), 1'b1, 3'd7, 32'hDEADBEEF);
    endtask

    task automatic t_data_busy;
        for (int r = 0; r < 4; r++)
            fast_read("R3 rebuild", flip(enc(32'h9C5A3781), r, 8'hA5), 1'b1, 3'(r), 32'h9C5A3781);
    endtask

    task automatic t_red_busy;
        fast_read("R4 chip4 busy", flip(enc(32'h0F1E2D3C), 4, 8'h77), 1'b1, 3'd4, 32'h0F1E2D3C);
        fast_read("R4 chip5 busy", flip(enc(32'h0F1E2D3C), 5, 8'h3B), 1'b1, 3'd5, 32'h0F1E2D3C);
    endtask

    task automatic t_busy_fault_fixed;
        logic [47:0] g;
        g = enc(32'h12345678);
        slow_read("R5 R8 fixed", flip(flip(g, 2, 8'hEE), 0, 8'h01), 1'b1, 3'd2,
                  flip(g, 1, 8'h10), 32'h12345678, 2'd2);
    endtask

    task automatic t_idle_fault_clean;
        logic [47:0] g;
        g = enc(32'hCAFEF00D);
        slow_read("R6 R7 clean reread", flip(g, 5, 8'h04), 1'b0, 3'd0, g, 32'hCAFEF00D, 2'd1);
    endtask

    task automatic t_unfixable;
        logic [47:0] g;
        g = enc(32'h55AA1234);
        slow_read("R9 parity only", flip(g, 3, 8'h08), 1'b1, 3'd5,
                  flip(g, 4, 8'h40), 32'h55AA1234, 2'd3);
        slow_read("R9 ambiguous", flip(g, 1, 8'hFF), 1'b0, 3'd0,
                  flip(g, 1, 8'hFF), 32'h55AA1234 ^ 32'h0000FF00, 2'd3);
    endtask

    task automatic t_backpressure;
        logic [31:0] first;
        out_ready = 1'b0;
        send(enc(32'h01020304), 1'b0, 3'd0);
        rsp_valid = 1'b1; rsp_syms = enc(32'hFFFF0000);
        first = out_data;
        for (int k = 0; k < 3; k++) begin
            chk("R10 hold valid", {63'd0, out_valid}, 64'd1);
            chk("R10 hold data", {32'd0, out_data}, {32'd0, first});
            chk("R10 not ready", {63'd0, rsp_ready}, 64'd0);
            @(negedge clk);
        end
        rsp_valid = 1'b0;
        chk("R10 data", {32'd0, first}, 64'h01020304);
        out_ready = 1'b1;
        @(negedge clk);
        idle_ok("R10 release");
    endtask

    task automatic t_stray_refetch;
        @(negedge clk);
        rrd_valid = 1'b1; rrd_syms = flip(enc(32'h11111111), 0, 8'h01);
        @(negedge clk);
        rrd_valid = 1'b0;
        chk("R11 no output", {63'd0, out_valid}, 64'd0);
        chk("R11 still ready", {63'd0, rsp_ready}, 64'd1);
        fast_read("R11 next read", enc(32'h2468ACE0), 1'b0, 3'd0, 32'h2468ACE0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        $display("FAIL watchdog actual=hung expected=done");
        bad++; total++;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_clean();
        t_data_busy();
        t_red_busy();
        t_busy_fault_fixed();
        t_idle_fault_clean();
        t_unfixable();
        t_backpressure();
        t_stray_refetch();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule